// File: doc/BRIEF.md
# Multiplexed Address Bus Cycle Sequencer

The sequencer sits between a core that issues byte reads and writes to a 16-bit address space and an external bus that has only eight shared address/data lines. For every accepted request it runs three bus cycles. The first carries the upper address byte and the second carries the lower address byte. In both of these an address latch strobe is high, and a half-select line tells the external latch which byte is on the lines. The third cycle moves the data byte.

A write drives the data byte in the data cycle and pulses the write strobe. A read releases the lines, pulses the read strobe and samples the bus at the closing clock edge of that cycle. One cycle later a single-cycle completion pulse tells the core the transfer has finished. The core hands over a request with a valid/ready handshake. Ready is high only while the sequencer is idle, and that includes the completion cycle, so transfers can run back to back with no gap.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted (rst_ni low, asynchronous) and in every idle cycle, ale_o, addr_hi_o, rd_o, wr_o and bus_oe_o are 0 and bus_out_o is 0. After reset, ready_o is 1, done_o is 0 and rdata_o is 0.
- R2: If req_valid_i and req_ready_o are both high at a rising edge, the request is accepted. In the next cycle ale_o=1, addr_hi_o=1, bus_oe_o=1 and bus_out_o = req_addr_i[15:8].
- R3: In the second bus cycle ale_o=1, addr_hi_o=0, bus_oe_o=1 and bus_out_o = req_addr_i[7:0].
- R4: In the third cycle of a write (req_we_i=1), ale_o=0, bus_oe_o=1, wr_o=1, rd_o=0 and bus_out_o = req_wdata_i.
- R5: In the third cycle of a read (req_we_i=0), ale_o=0, bus_oe_o=0, rd_o=1 and wr_o=0. bus_in_i is captured at the rising edge that ends this cycle and appears on rdata_o from the next cycle on. rdata_o holds that value until the next read completes, and writes leave it unchanged.
- R6: done_o is high for exactly one cycle: the cycle right after the data cycle.
- R7: req_ready_o is 0 during the three bus cycles. A request presented then is ignored and does not alter the transfer in progress.
- R8: rd_o and wr_o are never high together, and neither is ever high while ale_o is high.
- R9: A request accepted in the completion cycle starts its upper-address cycle in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last read data |
| bus_out_o | output | 8 | Value driven onto the shared lines |
| bus_oe_o | output | 1 | Drive enable for the shared lines |
| bus_in_i | input | 8 | Value sampled from the shared lines |
| ale_o | output | 1 | Address latch strobe |
| addr_hi_o | output | 1 | 1 = upper address byte present |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |

## Verification
Two things can happen in the same cycle: the completion pulse of one transfer and the acceptance of the next request. The bench provokes this by holding random requests valid for many cycles, so some of them are presented exactly in the completion cycle. Others are presented while the sequencer is busy and must be ignored. A behavioural reference model predicts every output on every cycle, and it judges that the completion pulse and the new upper-address cycle follow each other with no idle cycle between them. A reset in the middle of the run restarts the sequence from idle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ADDR_HI = 2'd1,
    ST_ADDR_LO = 2'd2,
    ST_DATA    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [2*DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [DATA_W-1:0]   bus_in_i,
  output seq_state_e          state_o,
  output logic [2*DATA_W-1:0] addr_o,
  output logic                we_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                ready_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int ADDR_W = 2 * DATA_W;

  seq_state_e          state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                done_q;
  logic [DATA_W-1:0]   rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= (state_q == ST_DATA);
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q <= ST_ADDR_HI;
            addr_q  <= req_addr_i;
            we_q    <= req_we_i;
            wdata_q <= req_wdata_i;
          end
        end
        ST_ADDR_HI: state_q <= ST_ADDR_LO;
        ST_ADDR_LO: state_q <= ST_DATA;
        ST_DATA: begin
          state_q <= ST_IDLE;
          // sample the released bus at the end of the read cycle
          if (!we_q) rdata_q <= bus_in_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign we_o    = we_q;
  assign wdata_o = wdata_q;
  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  a_r7_no_latch_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(addr_q) && $stable(we_q) && $stable(wdata_q));
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_ready_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
endmodule

// File: rtl/mbs_drive.sv
module mbs_drive
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  seq_state_e          state_i,
  input  logic [2*DATA_W-1:0] addr_i,
  input  logic                we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   bus_out_o,
  output logic                bus_oe_o,
  output logic                ale_o,
  output logic                addr_hi_o,
  output logic                rd_o,
  output logic                wr_o
);
  localparam int ADDR_W = 2 * DATA_W;

  always_comb begin
    bus_out_o = '0;
    bus_oe_o  = 1'b0;
    ale_o     = 1'b0;
    addr_hi_o = 1'b0;
    rd_o      = 1'b0;
    wr_o      = 1'b0;
    unique case (state_i)
      ST_ADDR_HI: begin
        ale_o     = 1'b1;
        addr_hi_o = 1'b1;
        bus_oe_o  = 1'b1;
        bus_out_o = addr_i[ADDR_W-1:DATA_W];
      end
      ST_ADDR_LO: begin
        ale_o     = 1'b1;
        bus_oe_o  = 1'b1;
        bus_out_o = addr_i[DATA_W-1:0];
      end
      ST_DATA: begin
        if (we_i) begin
          bus_oe_o  = 1'b1;
          wr_o      = 1'b1;
          bus_out_o = wdata_i;
        end else begin
          rd_o = 1'b1;
        end
      end
      default: ;
    endcase
  end

  a_r8_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  a_r8_ale_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !rd_o && !wr_o);
  a_r3_lo_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && addr_hi_o) |=> (ale_o && !addr_hi_o));
  a_r4_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> bus_oe_o);
  a_r5_release_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !bus_oe_o);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_we_i,
  input  logic [2*DATA_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                req_ready_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DATA_W-1:0]   bus_out_o,
  output logic                bus_oe_o,
  input  logic [DATA_W-1:0]   bus_in_i,
  output logic                ale_o,
  output logic                addr_hi_o,
  output logic                rd_o,
  output logic                wr_o
);
  localparam int ADDR_W = 2 * DATA_W;

  seq_state_e         state;
  logic [ADDR_W-1:0]  addr_q;
  logic               we_q;
  logic [DATA_W-1:0]  wdata_q;

  mbs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .bus_in_i    (bus_in_i),
    .state_o     (state),
    .addr_o      (addr_q),
    .we_o        (we_q),
    .wdata_o     (wdata_q),
    .ready_o     (req_ready_o),
    .done_o      (done_o),
    .rdata_o     (rdata_o)
  );

  mbs_drive #(.DATA_W(DATA_W)) u_drive (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .addr_i    (addr_q),
    .we_i      (we_q),
    .wdata_i   (wdata_q),
    .bus_out_o (bus_out_o),
    .bus_oe_o  (bus_oe_o),
    .ale_o     (ale_o),
    .addr_hi_o (addr_hi_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o)
  );

  a_r2_accept_starts_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (ale_o && addr_hi_o && !req_ready_o));
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !ale_o && !rd_o && !wr_o && !bus_oe_o);
endmodule

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  localparam int CLK_P = 10;
  localparam int NCYC  = 4000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic [7:0]  bus_in_i = '0;
  logic        req_ready_o, done_o, bus_oe_o, ale_o, addr_hi_o, rd_o, wr_o;
  logic [7:0]  rdata_o, bus_out_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mux_bus_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o),
    .done_o(done_o), .rdata_o(rdata_o), .bus_out_o(bus_out_o), .bus_oe_o(bus_oe_o),
    .bus_in_i(bus_in_i), .ale_o(ale_o), .addr_hi_o(addr_hi_o), .rd_o(rd_o), .wr_o(wr_o)
  );

  // reference model: phase 0 idle, 1 upper byte, 2 lower byte, 3 data
  int          m_phase;
  logic        m_we, m_done;
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_rdata;
  int          hit_b2b = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_we = 0; m_done = 0; m_addr = '0; m_wd = '0; m_rdata = '0;
    end else begin
      int old;
      old = m_phase;
      m_done = (old == 3);
      if (old == 3 && !m_we) m_rdata = bus_in_i;
      if (old == 0 || old == 3) begin
        m_phase = 0;
        if (req_valid_i && (old == 0)) begin
          m_phase = 1; m_we = req_we_i; m_addr = req_addr_i; m_wd = req_wdata_i;
        end
      end else begin
        m_phase = old + 1;
      end
    end
  end

  // R9: acceptance in the completion cycle is an idle-phase acceptance in the model,
  // because the model returns to phase 0 at the data-cycle edge.
  always @(posedge clk_i) begin
    if (rst_ni && m_done && req_valid_i) hit_b2b++;
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic       e_ale, e_hi, e_oe, e_rd, e_wr;
    logic [7:0] e_bus;
    string      tag;
    e_ale = 0; e_hi = 0; e_oe = 0; e_rd = 0; e_wr = 0; e_bus = '0; tag = "R1";
    case (m_phase)
      1: begin e_ale = 1; e_hi = 1; e_oe = 1; e_bus = m_addr[15:8]; tag = "R2"; end
      2: begin e_ale = 1; e_oe = 1; e_bus = m_addr[7:0]; tag = "R3"; end
      3: if (m_we) begin e_oe = 1; e_wr = 1; e_bus = m_wd; tag = "R4"; end
         else begin e_rd = 1; tag = "R5"; end
      default: ;
    endcase
    chk(req_ready_o == (m_phase == 0), "R7 ready", 16'(req_ready_o), 16'(m_phase == 0));
    chk(done_o == m_done, "R6 done", 16'(done_o), 16'(m_done));
    chk(rdata_o == m_rdata, "R5 rdata", 16'(rdata_o), 16'(m_rdata));
    chk(ale_o == e_ale, {tag, " ale"}, 16'(ale_o), 16'(e_ale));
    chk(addr_hi_o == e_hi, {tag, " addr_hi"}, 16'(addr_hi_o), 16'(e_hi));
    chk(bus_oe_o == e_oe, {tag, " oe"}, 16'(bus_oe_o), 16'(e_oe));
    chk(bus_out_o == e_bus, {tag, " bus"}, 16'(bus_out_o), 16'(e_bus));
    chk(rd_o == e_rd, {tag, " rd"}, 16'(rd_o), 16'(e_rd));
    chk(wr_o == e_wr, {tag, " wr"}, 16'(wr_o), 16'(e_wr));
    chk(!(rd_o && wr_o) && !(ale_o && (rd_o || wr_o)), "R8 strobe excl",
        {13'd0, ale_o, rd_o, wr_o}, 16'd0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(17);
    repeat (3) @(negedge clk_i);
    compare();  // R1 under reset
    rst_ni = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk_i);
      compare();
      if (c == NCYC / 2) begin
        rst_ni = 1'b0;  // R1 mid-run reset
        @(negedge clk_i);
        compare();
        rst_ni = 1'b1;
      end
      // keep a request valid for several cycles so some land in busy and done cycles
      if (!req_valid_i || ($urandom % 4 == 0)) begin
        req_valid_i = ($urandom % 3) != 0;
        req_we_i    = $urandom % 2;
        req_addr_i  = 16'($urandom);
        req_wdata_i = 8'($urandom);
      end
      bus_in_i = 8'($urandom);
    end
    chk(hit_b2b > 0, "R9 back-to-back seen", 16'(hit_b2b), 16'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule